// File: doc/BRIEF.md
# Channel Interrupt Status Latch

This block keeps the interrupt state for every channel of a multi-channel DMA engine. Each channel's transfer engine presents a live event vector. The block latches those events into a request word, gates the request word with a per-channel enable mask, and drives one interrupt output per channel from the gated result. Only two event bits are implemented. Bit 1 marks transfer done and bit 13 marks abort. All other bit positions are not stored and always read as zero.

Software sees four words per channel through a simple write/read port. The word at offset 0x10 shows the live events. The word at offset 0x14 is the latched request, and writing ones to it clears bits. The word at offset 0x18 is the enable mask. The word at offset 0x1C is the masked result and is read-only.

Channels are grouped onto shared interrupt lines, so a handler that owns a line has to inspect the masked word of each member channel. An abort always lands in the request word, whatever the enable mask says, so a driver can poll for abort completion with interrupts switched off.

Top module: `irqlat_top`

## Requirements
- R1: After reset, every request word and every enable mask is zero, all channel and line interrupt outputs are low, and the read data output is zero.
- R2: A read of offset 0x10 returns the channel's event input at the read edge, masked to bits 1 and 13. A read of any offset other than 0x10, 0x14, 0x18 or 0x1C returns zero.
- R3: An event bit that is high at a clock edge is set in the request word (offset 0x14) from the next cycle onward.
- R4: Writing to offset 0x14 clears each request bit whose write-data bit is one. Request bits whose write-data bit is zero are left unchanged.
- R5: If an event and a clearing write hit the same request bit on the same edge, the bit remains set.
- R6: The enable mask at offset 0x18 is written directly. Only bits 1 and 13 are stored, and every other bit reads as zero.
- R7: Offset 0x1C always reads as the request word ANDed with the enable mask. Writes to offsets 0x10 and 0x1C have no effect.
- R8: A channel's interrupt output is high exactly when its masked word is non-zero. It rises in the cycle after the event edge that latched the request.
- R9: Line k is the OR of the interrupt outputs of channels k*CH_PER_LINE up to k*CH_PER_LINE+CH_PER_LINE-1. A channel whose masked word is zero does not raise its line.
- R10: An abort event sets request bit 13 even when enable bit 13 is clear, and in that case it raises no interrupt.
- R11: Read data is registered. It appears in the cycle after a read strobe and holds until the next strobe. Reads change no state.
- R12: The channel is selected by the address bits above bit 5. A write to one channel leaves every other channel's words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCH*DW | Live event vectors, channel c in bits c*DW+DW-1 down to c*DW |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: channel index above bit 5, word offset in bits 5:0 |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read address, same layout as wr_addr |
| rd_data | output | DW | Registered read data |
| irq_ch_o | output | NCH | Per-channel interrupt outputs |
| irq_line_o | output | NLINE | Shared interrupt lines |

## Verification
On every cycle, the assertions check the latch rules. Events set request bits, cleared bits drop, and untouched bits hold. Events win against a simultaneous clear. The enable mask holds when it is not written. An abort is latched with its enable off. A raised interrupt implies a non-zero request and enable. The lines agree with the channel outputs. Only the bench scenarios can show the register map as software sees it: the offsets, read latency, masked read-back of unimplemented bits, ignored writes to read-only words, channel isolation, and how channels group onto lines.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;

    localparam int OFS_W     = 6;
    localparam int BIT_DONE  = 1;
    localparam int BIT_ABORT = 13;

    localparam logic [OFS_W-1:0] OFS_STAT = 6'h10;
    localparam logic [OFS_W-1:0] OFS_REQ  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_EN   = 6'h18;
    localparam logic [OFS_W-1:0] OFS_DET  = 6'h1C;

    typedef enum logic [1:0] {
        VIEW_STAT = 2'd0,
        VIEW_REQ  = 2'd1,
        VIEW_EN   = 2'd2,
        VIEW_DET  = 2'd3
    } view_e;

    typedef struct packed {
        logic  hit;
        view_e view;
    } view_dec_t;

    function automatic view_dec_t decode_ofs(input logic [OFS_W-1:0] ofs);
        view_dec_t d;
        d.hit  = 1'b1;
        d.view = VIEW_STAT;
        case (ofs)
            OFS_STAT: d.view = VIEW_STAT;
            OFS_REQ:  d.view = VIEW_REQ;
            OFS_EN:   d.view = VIEW_EN;
            OFS_DET:  d.view = VIEW_DET;
            default:  d.hit  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irqlat_chan.sv
module irqlat_chan
    import irqlat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt_i,
    input  logic          req_wr_i,
    input  logic          en_wr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] req_o,
    output logic [DW-1:0] en_o,
    output logic [DW-1:0] det_o,
    output logic          irq_o
);

    localparam logic [DW-1:0] IMPL = (DW'(1) << BIT_DONE) | (DW'(1) << BIT_ABORT);

    logic [DW-1:0] status;
    logic [DW-1:0] clr;
    logic [DW-1:0] req_q;
    logic [DW-1:0] en_q;

    assign status = evt_i & IMPL;
    assign clr    = req_wr_i ? wr_data_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            en_q  <= '0;
        end else begin
            req_q <= (req_q & ~clr) | status;
            if (en_wr_i)
                en_q <= wr_data_i & IMPL;
        end
    end

    assign status_o = status;
    assign req_o    = req_q;
    assign en_o     = en_q;
    assign det_o    = req_q & en_q;
    assign irq_o    = |det_o;

    // R3
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|status) |=> ((req_q & $past(status)) == $past(status)));

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        req_wr_i |=> ((req_q & $past(wr_data_i & ~status)) == '0));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_wr_i |=> (($past(req_q) & ~req_q) == '0));

    // R5
    race_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr_i && |(wr_data_i & status))
        |=> ((req_q & $past(wr_data_i & status)) == $past(wr_data_i & status)));

    // R6
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_wr_i |=> (en_q == $past(en_q)));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (req_q != '0 && en_q != '0));

    // R10
    abort_vis_chk: assert property (@(posedge clk) disable iff (rst)
        (status[BIT_ABORT] && !en_q[BIT_ABORT] && !en_wr_i)
        |=> (req_q[BIT_ABORT] && !det_o[BIT_ABORT]));

endmodule

// File: rtl/irqlat_regif.sv
module irqlat_regif
    import irqlat_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 32,
    parameter int CH_W = 2,
    parameter int AW   = CH_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [NCH*DW-1:0] status_i,
    input  logic [NCH*DW-1:0] req_i,
    input  logic [NCH*DW-1:0] en_i,
    input  logic [NCH*DW-1:0] det_i,
    output logic [NCH-1:0]    req_wr_o,
    output logic [NCH-1:0]    en_wr_o,
    output logic [DW-1:0]     rd_data
);

    logic [CH_W-1:0] wr_ch;
    logic [CH_W-1:0] rd_ch;
    view_dec_t       wr_dec;
    view_dec_t       rd_dec;
    logic [DW-1:0]   rd_mux;

    assign wr_ch  = wr_addr[AW-1:OFS_W];
    assign rd_ch  = rd_addr[AW-1:OFS_W];
    assign wr_dec = decode_ofs(wr_addr[OFS_W-1:0]);
    assign rd_dec = decode_ofs(rd_addr[OFS_W-1:0]);

    for (genvar c = 0; c < NCH; c++) begin : g_wr
        logic sel;
        assign sel         = wr_en && wr_dec.hit && (wr_ch == CH_W'(c));
        assign req_wr_o[c] = sel && (wr_dec.view == VIEW_REQ);
        assign en_wr_o[c]  = sel && (wr_dec.view == VIEW_EN);
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_dec.hit && (rd_ch == CH_W'(c))) begin
                case (rd_dec.view)
                    VIEW_STAT: rd_mux = status_i[c*DW +: DW];
                    VIEW_REQ:  rd_mux = req_i[c*DW +: DW];
                    VIEW_EN:   rd_mux = en_i[c*DW +: DW];
                    default:   rd_mux = det_i[c*DW +: DW];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R12
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_wr_o | en_wr_o));

endmodule

// File: rtl/irqlat_share.sv
module irqlat_share #(
    parameter int NCH         = 4,
    parameter int CH_PER_LINE = 2,
    parameter int NLINE       = (NCH + CH_PER_LINE - 1) / CH_PER_LINE
) (
    input  logic [NCH-1:0]   irq_ch_i,
    output logic [NLINE-1:0] irq_line_o
);

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        always_comb begin
            irq_line_o[l] = 1'b0;
            for (int k = 0; k < CH_PER_LINE; k++) begin
                if (l*CH_PER_LINE + k < NCH)
                    irq_line_o[l] = irq_line_o[l] | irq_ch_i[l*CH_PER_LINE + k];
            end
        end
    end

endmodule

// File: rtl/irqlat_top.sv
module irqlat_top
    import irqlat_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 32,
    parameter int CH_PER_LINE = 2,
    parameter int CH_W        = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int AW          = CH_W + OFS_W,
    parameter int NLINE       = (NCH + CH_PER_LINE - 1) / CH_PER_LINE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH*DW-1:0] evt_i,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [NCH-1:0]    irq_ch_o,
    output logic [NLINE-1:0]  irq_line_o
);

    logic [NCH*DW-1:0] status_w;
    logic [NCH*DW-1:0] req_w;
    logic [NCH*DW-1:0] en_w;
    logic [NCH*DW-1:0] det_w;
    logic [NCH-1:0]    req_wr_w;
    logic [NCH-1:0]    en_wr_w;

    irqlat_regif #(.NCH(NCH), .DW(DW), .CH_W(CH_W), .AW(AW)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .status_i (status_w),
        .req_i    (req_w),
        .en_i     (en_w),
        .det_i    (det_w),
        .req_wr_o (req_wr_w),
        .en_wr_o  (en_wr_w),
        .rd_data  (rd_data)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        irqlat_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .evt_i     (evt_i[c*DW +: DW]),
            .req_wr_i  (req_wr_w[c]),
            .en_wr_i   (en_wr_w[c]),
            .wr_data_i (wr_data),
            .status_o  (status_w[c*DW +: DW]),
            .req_o     (req_w[c*DW +: DW]),
            .en_o      (en_w[c*DW +: DW]),
            .det_o     (det_w[c*DW +: DW]),
            .irq_o     (irq_ch_o[c])
        );
    end

    irqlat_share #(.NCH(NCH), .CH_PER_LINE(CH_PER_LINE), .NLINE(NLINE)) u_share (
        .irq_ch_i   (irq_ch_o),
        .irq_line_o (irq_line_o)
    );

    // R9
    line_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_ch_o) == (|irq_line_o));

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (irq_ch_o == '0 && irq_line_o == '0));

endmodule

// File: tb/sim_irqlat_top.sv
module sim_irqlat_top;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH*DW-1:0] evt_i = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic [NCH-1:0]    irq_ch_o;
    logic [1:0]        irq_line_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [5:0] O_ST = 6'h10, O_RQ = 6'h14, O_EN = 6'h18, O_DT = 6'h1C;

    always #2 clk = ~clk;

    irqlat_top u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_ch_o(irq_ch_o), .irq_line_o(irq_line_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [5:0] ofs, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {2'(ch), ofs}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [5:0] ofs, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = {2'(ch), ofs};
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input int ch, input logic [31:0] bits);
        @(negedge clk);
        evt_i[ch*DW +: DW] = bits;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq_ch", 32'(irq_ch_o), 0);
        chk("R1 irq_line", 32'(irq_line_o), 0);
        chk("R1 rd_data", rd_data, 0);
        rd(0, O_RQ, v); chk("R1 req", v, 0);
        rd(3, O_EN, v); chk("R1 en", v, 0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk);
        evt_i[1*DW +: DW] = 32'hFFFF_FFFF;
        rd_en = 1'b1; rd_addr = {2'd1, O_ST};
        @(negedge clk);
        rd_en = 1'b0; evt_i = '0;
        chk("R2 status", rd_data, 32'h0000_2002);
        rd(1, O_RQ, v); chk("R3 req from status", v, 32'h0000_2002);
        rd(1, 6'h20, v); chk("R2 unmapped", v, 0);
        wr(1, O_RQ, 32'hFFFF_FFFF);
        rd(1, O_RQ, v); chk("R4 clear all", v, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(2, 32'h0000_0002);
        rd(2, O_RQ, v); chk("R3 done latched", v, 32'h2);
        chk("R8 no irq when disabled", 32'(irq_ch_o), 0);
        pulse(2, 32'h0000_2000);
        rd(2, O_RQ, v); chk("R3 both latched", v, 32'h2002);
        wr(2, O_RQ, 32'h0);
        rd(2, O_RQ, v); chk("R4 zero write keeps", v, 32'h2002);
        wr(2, O_RQ, 32'h2);
        rd(2, O_RQ, v); chk("R4 clear done", v, 32'h2000);
        wr(2, O_RQ, 32'h2000);
        rd(2, O_RQ, v); chk("R4 clear abort", v, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        @(negedge clk);
        evt_i[0 +: DW] = 32'h2;
        wr_en = 1'b1; wr_addr = {2'd0, O_RQ}; wr_data = 32'h2;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0;
        rd(0, O_RQ, v); chk("R5 event wins", v, 32'h2);
        wr(0, O_RQ, 32'h2);
        rd(0, O_RQ, v); chk("R5 later clear", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(0, O_EN, 32'hFFFF_FFFF);
        rd(0, O_EN, v); chk("R6 en masked", v, 32'h2002);
        wr(0, O_EN, 32'h2);
        rd(0, O_EN, v); chk("R6 en write", v, 32'h2);
    endtask

    task automatic t_detect();
        logic [31:0] v;
        pulse(0, 32'h2002);
        chk("R8 irq ch0", 32'(irq_ch_o), 32'h1);
        chk("R9 line0", 32'(irq_line_o), 32'h1);
        rd(0, O_DT, v); chk("R7 detect", v, 32'h2);
        wr(0, O_DT, 32'hFFFF_FFFF);
        wr(0, O_ST, 32'hFFFF_FFFF);
        rd(0, O_DT, v); chk("R7 detect after ro writes", v, 32'h2);
        rd(0, O_RQ, v); chk("R7 req after ro writes", v, 32'h2002);
        rd(0, O_RQ, v); chk("R11 read no side effect", v, 32'h2002);
        wr(0, O_RQ, 32'h2);
        chk("R8 irq low, abort unmasked off", 32'(irq_ch_o), 0);
        rd(0, O_DT, v); chk("R7 detect zero", v, 0);
        wr(0, O_RQ, 32'h2000);
    endtask

    task automatic t_share();
        logic [31:0] v;
        pulse(2, 32'h2);
        chk("R9 zero detect no line", 32'(irq_line_o), 0);
        wr(3, O_EN, 32'h2000);
        @(negedge clk);
        evt_i[3*DW +: DW] = 32'h2000;
        chk("R8 irq before latch", 32'(irq_ch_o), 0);
        @(negedge clk);
        evt_i = '0;
        chk("R8 irq ch3", 32'(irq_ch_o), 32'h8);
        chk("R9 line1", 32'(irq_line_o), 32'h2);
        wr(3, O_RQ, 32'h2000);
        chk("R9 line1 released", 32'(irq_line_o), 0);
        wr(2, O_RQ, 32'hFFFF_FFFF);
        rd(2, O_RQ, v); chk("R4 ch2 cleared", v, 0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        pulse(1, 32'h2000);
        chk("R10 no irq", 32'(irq_ch_o), 0);
        rd(1, O_RQ, v); chk("R10 abort latched", v, 32'h2000);
        wr(1, O_RQ, 32'h2000);
    endtask

    task automatic t_indep();
        logic [31:0] v;
        wr(1, O_EN, 32'h2002);
        rd(0, O_EN, v); chk("R12 ch0 en kept", v, 32'h2);
        rd(3, O_EN, v); chk("R12 ch3 en kept", v, 32'h2000);
        rd(1, O_EN, v); chk("R12 ch1 en", v, 32'h2002);
        @(negedge clk);
        chk("R11 rd_data holds", rd_data, 32'h2002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_status();
        t_w1c();
        t_race();
        t_enable();
        t_detect();
        t_share();
        t_abort();
        t_indep();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule